// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block steers each access that falls in the legacy window from 0xA0000 to 0xFFFFF. It decides whether the access is served by system DRAM or passed on to the expansion bus. For DRAM-mapped areas it also decides whether a write may proceed. The decision is made without a clock edge, from the access address, the write strobe and a small set of configuration bytes. These bytes are one byte of attribute codes per pair of segments, a control byte for the 128KB video area, and the installed-memory byte that sets the top of memory. A system-management-mode input takes part in the video-area decision.

Configuration is written one dword at a time, with byte enables. Each register byte sits at a fixed byte offset, and those offsets are part of the interface. The block also raises a one-cycle `mapUpdate` pulse whenever the address map may have moved. Logic that caches routing decisions can use that pulse to refresh its state.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset, the attribute bytes at offsets 0x59..0x5F read 0x00 and the control byte at 0x72 reads 0x02. The size byte at 0x57 reads min(RAM_MIB/8, 255), which is 0x10 by default. Every other byte reads 0x00.
- R2: A write selects dword `cfgDword` (byte offset = 4*cfgDword). Lane n, meaning data bits [8n+7:8n] and enable bit n, goes to byte offset 4*cfgDword+n. The new value reads back from the next cycle on. Only offsets 0x57, 0x59..0x5F and 0x72 store data. Writes to any other offset change nothing.
- R3: The 64KB segment 0xF0000..0xFFFFF takes its 2-bit code from bits [5:4] of byte 0x59.
- R4: The 16KB segment i = (addr-0xC0000)>>14, for i = 0..11, takes its code from byte 0x5A+(i>>1). It uses bits [1:0] when i is even and bits [5:4] when i is odd. The other bits of the attribute bytes have no effect on decode.
- R5: Code 3 routes the access to DRAM (`accToDram`=1) and permits writes.
- R6: Code 1 routes the access to DRAM, but a write gets `accWrEn`=0, so the write is dropped.
- R7: Codes 0 and 2 route the access to the bus (`accToDram`=0), and writes are permitted.
- R8: An access to 0xA0000..0xBFFFF goes to DRAM when bit 6 of byte 0x72 is set, or when bit 3 is set and `smmActive` is 1. Otherwise it goes to the bus. Writes there are always permitted.
- R9: An address outside 0xA0000..0xFFFFF goes to DRAM exactly when it is below (size byte)*8MB, and writes to it are permitted.
- R10: `accWrEn` is 0 whenever `accWrite` is 0.
- R11: `mapUpdate` is 1 for one cycle in two cases. One is the cycle after a write whose enabled lanes cover any of 0x59..0x5F or 0x72. The other is the cycle after `smmActive` differs from its value on the previous clock. In every other cycle it is 0, including after writes that touch only 0x57.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDword | input | 6 | Dword index of the write |
| cfgByteEn | input | 4 | Per-lane write enables |
| cfgWrData | input | 32 | Write data, lane n in bits [8n+7:8n] |
| cfgRdDword | input | 6 | Dword index for read-back |
| cfgRdData | output | 32 | Read-back data of the selected dword |
| smmActive | input | 1 | System-management mode is active |
| accAddr | input | ADDR_W | Access address |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| accToDram | output | 1 | 1 when DRAM serves the access, 0 when the bus does |
| accWrEn | output | 1 | 1 when a write access may proceed |
| mapUpdate | output | 1 | One-cycle pulse after the map may have changed |

## Verification
The clocked assertions cover several rules on every cycle. A read never carries a write enable. A closed video area never reaches DRAM. Only attribute-coded segments can drop a write. Register bytes change only under their own strobes. A change of the mode input is always followed by an update pulse. The exact mapping of every segment to its byte and nibble can only be shown by the bench, which sweeps all codes over every segment with non-zero filler bits, and so can the top-of-memory boundary, the reset contents and partial-lane writes.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  localparam int ATTR_BYTES = 7;
  localparam int SEG16_COUNT = 12;

  localparam logic [7:0] OFS_SIZE  = 8'h57;
  localparam logic [7:0] OFS_ATTR  = 8'h59;
  localparam logic [7:0] OFS_SMRAM = 8'h72;

  localparam logic [7:0] ATTR_RST  = 8'h00;
  localparam logic [7:0] SMRAM_RST = 8'h02;

  localparam int SMRAM_OPEN_BIT = 6;
  localparam int SMRAM_SMM_BIT  = 3;

  // 8MB granule of the size byte
  localparam int SIZE_SHIFT = 23;

  typedef enum logic [1:0] {
    ATTR_BUS_A = 2'd0,
    ATTR_RDONLY = 2'd1,
    ATTR_BUS_B = 2'd2,
    ATTR_RDWR = 2'd3
  } attrCode_e;

  typedef struct packed {
    logic [ATTR_BYTES-1:0] attrWe;
    logic                  sizeWe;
    logic                  smramWe;
  } cfgStrobe_t;

endpackage

// File: rtl/lwd_ctrl.sv
module lwd_ctrl
  import lwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [5:0] cfgDword,
  input  logic [3:0] cfgByteEn,
  input  logic       smmActive,
  output cfgStrobe_t strobe,
  output logic       mapUpdate
);

  logic [ATTR_BYTES-1:0] attrHit;
  logic sizeHit;
  logic smramHit;
  logic smmQ;

  for (genvar k = 0; k < ATTR_BYTES; k++) begin : g_attr_hit
    localparam logic [7:0] OFS = OFS_ATTR + 8'(k);
    assign attrHit[k] = cfgWrEn && (cfgDword == OFS[7:2]) && cfgByteEn[OFS[1:0]];
  end

  assign sizeHit  = cfgWrEn && (cfgDword == OFS_SIZE[7:2]) && cfgByteEn[OFS_SIZE[1:0]];
  assign smramHit = cfgWrEn && (cfgDword == OFS_SMRAM[7:2]) && cfgByteEn[OFS_SMRAM[1:0]];

  always_comb begin
    strobe.attrWe  = attrHit;
    strobe.sizeWe  = sizeHit;
    strobe.smramWe = smramHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smmQ      <= smmActive;
      mapUpdate <= 1'b0;
    end else begin
      smmQ      <= smmActive;
      mapUpdate <= (|attrHit) || smramHit || (smmActive != smmQ);
    end
  end

  // R11: a mode change is always followed by an update pulse
  assert_smm_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (smmActive != $past(smmActive)) |=> mapUpdate);

  // R11: no write and a steady mode input leave the pulse low
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgWrEn && smmActive == $past(smmActive)) |=> !mapUpdate);

endmodule

// File: rtl/lwd_regs.sv
module lwd_regs
  import lwd_pkg::*;
#(
  parameter int RAM_MIB = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  cfgStrobe_t                  strobe,
  input  logic [31:0]                 cfgWrData,
  input  logic [5:0]                  cfgRdDword,
  output logic [31:0]                 cfgRdData,
  output logic [ATTR_BYTES-1:0][7:0]  attrBytes,
  output logic [7:0]                  sizeByte,
  output logic [7:0]                  smramByte
);

  localparam int SIZE_UNITS = RAM_MIB / 8;
  localparam logic [7:0] SIZE_RST = (SIZE_UNITS > 255) ? 8'hFF : 8'(SIZE_UNITS);
  localparam int SIZE_LANE  = int'(OFS_SIZE[1:0]);
  localparam int SMRAM_LANE = int'(OFS_SMRAM[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ATTR_BYTES; k++) attrBytes[k] <= ATTR_RST;
      sizeByte  <= SIZE_RST;
      smramByte <= SMRAM_RST;
    end else begin
      for (int k = 0; k < ATTR_BYTES; k++) begin
        if (strobe.attrWe[k])
          attrBytes[k] <= cfgWrData[((int'(OFS_ATTR) + k) % 4) * 8 +: 8];
      end
      if (strobe.sizeWe)  sizeByte  <= cfgWrData[SIZE_LANE*8 +: 8];
      if (strobe.smramWe) smramByte <= cfgWrData[SMRAM_LANE*8 +: 8];
    end
  end

  function automatic logic [7:0] byteAt(input logic [7:0] ofs);
    logic [7:0] v;
    v = 8'h00;
    if (ofs == OFS_SIZE)  v = sizeByte;
    if (ofs == OFS_SMRAM) v = smramByte;
    for (int k = 0; k < ATTR_BYTES; k++)
      if (ofs == OFS_ATTR + 8'(k)) v = attrBytes[k];
    return v;
  endfunction

  always_comb begin
    for (int ln = 0; ln < 4; ln++)
      cfgRdData[ln*8 +: 8] = byteAt({cfgRdDword, 2'(ln)});
  end

  // R2: control byte takes its lane on a strobe
  assert_smram_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.smramWe |=> smramByte == $past(cfgWrData[SMRAM_LANE*8 +: 8]));

  // R2: attribute bytes hold without a strobe
  assert_attr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|strobe.attrWe) |=> $stable(attrBytes));

  // R2: size byte holds without a strobe
  assert_size_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.sizeWe |=> $stable(sizeByte));

endmodule

// File: rtl/lwd_decode.sv
module lwd_decode
  import lwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          accAddr,
  input  logic                       accWrite,
  input  logic                       smmActive,
  input  logic [ATTR_BYTES-1:0][7:0] attrBytes,
  input  logic [7:0]                 sizeByte,
  input  logic [7:0]                 smramByte,
  output logic                       accToDram,
  output logic                       accWrEn
);

  localparam int CMP_W = ((ADDR_W > 31) ? ADDR_W : 31) + 1;
  localparam logic [5:0] SEG16_BASE = 6'h30;

  logic       lowMeg;
  logic [3:0] nib;
  logic       inVideo;
  logic       inExp;
  logic       inTop;
  logic [3:0] segIdx;
  logic [2:0] attrSel;
  logic [7:0] selByte;
  attrCode_e  code;
  logic [CMP_W-1:0] tomVal;
  logic [CMP_W-1:0] addrExt;
  logic belowTom;
  logic videoOpen;

  assign lowMeg  = (accAddr[ADDR_W-1:20] == '0);
  assign nib     = accAddr[19:16];
  assign inVideo = lowMeg && (nib == 4'hA || nib == 4'hB);
  assign inExp   = lowMeg && (nib == 4'hC || nib == 4'hD || nib == 4'hE);
  assign inTop   = lowMeg && (nib == 4'hF);

  assign segIdx  = 4'(accAddr[19:14] - SEG16_BASE);
  assign attrSel = inTop ? 3'd0 : 3'(segIdx[3:1] + 3'd1);
  assign selByte = attrBytes[attrSel];

  always_comb begin
    if (inTop || !segIdx[0]) code = attrCode_e'(inTop ? selByte[5:4] : selByte[1:0]);
    else                     code = attrCode_e'(selByte[5:4]);
  end

  assign tomVal    = CMP_W'(sizeByte) << SIZE_SHIFT;
  assign addrExt   = CMP_W'(accAddr);
  assign belowTom  = addrExt < tomVal;
  assign videoOpen = smramByte[SMRAM_OPEN_BIT] || (smramByte[SMRAM_SMM_BIT] && smmActive);

  always_comb begin
    accToDram = 1'b0;
    accWrEn   = accWrite;
    if (inVideo) begin
      accToDram = videoOpen;
    end else if (inExp || inTop) begin
      unique case (code)
        ATTR_RDWR:   accToDram = 1'b1;
        ATTR_RDONLY: begin
          accToDram = 1'b1;
          accWrEn   = 1'b0;
        end
        default:     accToDram = 1'b0;
      endcase
    end else begin
      accToDram = belowTom;
    end
  end

  // R10: reads never carry a write permission
  assert_wren_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accWrEn |-> accWrite);

  // R8: closed video area never goes to DRAM
  assert_video_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inVideo && !smramByte[SMRAM_OPEN_BIT] && !(smramByte[SMRAM_SMM_BIT] && smmActive))
      |-> !accToDram);

  // R6: only attribute-coded segments can drop a write
  assert_drop_only_in_segments_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accWrite && !accWrEn) |-> (inExp || inTop) && accToDram);

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
  import lwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RAM_MIB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [5:0]        cfgDword,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  input  logic [5:0]        cfgRdDword,
  output logic [31:0]       cfgRdData,
  input  logic              smmActive,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic              accToDram,
  output logic              accWrEn,
  output logic              mapUpdate
);

  cfgStrobe_t strobe;
  logic [ATTR_BYTES-1:0][7:0] attrBytes;
  logic [7:0] sizeByte;
  logic [7:0] smramByte;

  lwd_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgDword  (cfgDword),
    .cfgByteEn (cfgByteEn),
    .smmActive (smmActive),
    .strobe    (strobe),
    .mapUpdate (mapUpdate)
  );

  lwd_regs #(.RAM_MIB(RAM_MIB)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .cfgRdDword (cfgRdDword),
    .cfgRdData  (cfgRdData),
    .attrBytes  (attrBytes),
    .sizeByte   (sizeByte),
    .smramByte  (smramByte)
  );

  lwd_decode #(.ADDR_W(ADDR_W)) decode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accAddr   (accAddr),
    .accWrite  (accWrite),
    .smmActive (smmActive),
    .attrBytes (attrBytes),
    .sizeByte  (sizeByte),
    .smramByte (smramByte),
    .accToDram (accToDram),
    .accWrEn   (accWrEn)
  );

endmodule

// File: tb/legacy_window_decoder_tb.sv
`timescale 1ns/1ps
module legacy_window_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgDword = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [5:0]  cfgRdDword = '0;
  logic [31:0] cfgRdData;
  logic        smmActive = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accToDram;
  logic        accWrEn;
  logic        mapUpdate;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  bit lastPulse;

  // bench mirror of the programmed state
  int  segCode[13];   // 0..11 sixteen-KB segments, 12 = top 64KB
  int  sizeMirror = 16;
  logic [7:0] smramMirror = 8'h02;

  always #2.5 clk = ~clk;

  legacy_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgDword(cfgDword),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdDword(cfgRdDword),
    .cfgRdData(cfgRdData), .smmActive(smmActive), .accAddr(accAddr),
    .accWrite(accWrite), .accToDram(accToDram), .accWrEn(accWrEn),
    .mapUpdate(mapUpdate)
  );

  task automatic check(input string tag, input longint act, input longint exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDword = 6'(dw); cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    lastPulse = mapUpdate;
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic readCheck(input string tag, input int dw, input logic [31:0] exp);
    @(negedge clk);
    cfgRdDword = 6'(dw);
    #1;
    check(tag, longint'(cfgRdData), longint'(exp), $sformatf("read dword 0x%0h", dw * 4));
  endtask

  function automatic void model(input longint a, input bit wr, output bit dram, output bit we);
    int c;
    we = wr;
    if (a >= 64'hA0000 && a <= 64'hBFFFF) begin
      dram = smramMirror[6] | (smramMirror[3] & smmActive);
    end else if (a >= 64'hC0000 && a <= 64'hFFFFF) begin
      c = (a >= 64'hF0000) ? segCode[12] : segCode[int'((a - 64'hC0000) / 16384)];
      dram = (c == 3 || c == 1);
      if (c == 1) we = 1'b0;
    end else begin
      dram = a < (longint'(sizeMirror) * 8388608);
    end
  endfunction

  task automatic accCheck(input string tag, input longint a, input bit wr);
    bit expD, expW;
    @(negedge clk);
    accAddr = 32'(a); accWrite = wr;
    #1;
    model(a, wr, expD, expW);
    check(tag, longint'(accToDram), longint'(expD), $sformatf("accToDram addr=%h wr=%0d", a, wr));
    check(wr ? tag : {tag, "/R10"}, longint'(accWrEn), longint'(expW),
          $sformatf("accWrEn addr=%h wr=%0d", a, wr));
  endtask

  function automatic string codeTag(input int c);
    if (c == 3) return "R5";
    if (c == 1) return "R6";
    return "R7";
  endfunction

  task automatic programAttr(input int junk);
    logic [7:0] b[7];
    b[0] = 8'(segCode[12] << 4) | 8'(junk);
    for (int j = 1; j < 7; j++)
      b[j] = 8'(segCode[2*(j-1)+1] << 4) | 8'(segCode[2*(j-1)]) | 8'(junk);
    cfgWrite(6'h16, 4'b1110, {b[2], b[1], b[0], 8'hEE});
    check("R11", lastPulse, 1, "pulse after attribute write");
    cfgWrite(6'h17, 4'b1111, {b[6], b[5], b[4], b[3]});
    readCheck("R2", 6'h16, {b[2], b[1], b[0], 8'h00});
    readCheck("R2", 6'h17, {b[6], b[5], b[4], b[3]});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 13; s++) segCode[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents
    readCheck("R1", 6'h15, 32'h1000_0000);
    readCheck("R1", 6'h16, 32'h0000_0000);
    readCheck("R1", 6'h17, 32'h0000_0000);
    readCheck("R1", 6'h1C, 32'h0002_0000);
    readCheck("R1", 6'h00, 32'h0000_0000);
    @(negedge clk);
    check("R1", longint'(mapUpdate), 0, "mapUpdate after reset");
    accCheck("R1/R7", 64'hC0000, 1'b0);
    accCheck("R1/R8", 64'hA0000, 1'b0);

    // R2/R11 write outside stored bytes is ignored and raises no pulse
    cfgWrite(6'h16, 4'b0001, 32'hAABB_CCDD);
    check("R11", lastPulse, 0, "pulse after unstored-byte write");
    readCheck("R2", 6'h16, 32'h0000_0000);
    cfgWrite(6'h20, 4'b1111, 32'hFFFF_FFFF);
    readCheck("R2", 6'h20, 32'h0000_0000);

    // R3/R4 sweep all codes over all segments
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 13; s++) segCode[s] = (s + p) % 4;
      programAttr((p % 2) ? 8'hCC : 8'h00);
      for (int s = 0; s < 12; s++) begin
        for (int w = 0; w < 2; w++) begin
          longint base = 64'hC0000 + longint'(s) * 16384;
          accCheck({"R4/", codeTag(segCode[s])}, base, w[0]);
          accCheck({"R4/", codeTag(segCode[s])}, base + 16383, w[0]);
        end
      end
      for (int w = 0; w < 2; w++) begin
        accCheck({"R3/", codeTag(segCode[12])}, 64'hF0000, w[0]);
        accCheck({"R3/", codeTag(segCode[12])}, 64'hF8000, w[0]);
        accCheck({"R3/", codeTag(segCode[12])}, 64'hFFFFF, w[0]);
      end
    end

    // R8 video area over control bits and mode input
    for (int c = 0; c < 4; c++) begin
      smramMirror = 8'h02 | (c[0] ? 8'h08 : 8'h00) | (c[1] ? 8'h40 : 8'h00);
      cfgWrite(6'h1C, 4'b0100, {8'h00, smramMirror, 16'h0000});
      check("R11", lastPulse, 1, "pulse after control write");
      readCheck("R2", 6'h1C, {8'h00, smramMirror, 16'h0000});
      for (int m = 0; m < 2; m++) begin
        @(negedge clk);
        smmActive = m[0];
        @(negedge clk);
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
          accCheck("R8", 64'hA0000, w[0]);
          accCheck("R8", 64'hBFFFF, w[0]);
        end
      end
    end

    // R11 mode input change pulse timing
    @(negedge clk);
    smmActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11", longint'(mapUpdate), 0, "idle pulse");
    smmActive = 1'b1;
    @(negedge clk);
    check("R11", longint'(mapUpdate), 1, "pulse after mode rise");
    @(negedge clk);
    check("R11", longint'(mapUpdate), 0, "pulse lasts one cycle");
    smmActive = 1'b0;
    @(negedge clk);
    check("R11", longint'(mapUpdate), 1, "pulse after mode fall");

    // R9 top of memory, default then reprogrammed
    accCheck("R9", 64'h0, 1'b1);
    accCheck("R9", 64'h9FFFF, 1'b0);
    accCheck("R9", 64'h100000, 1'b1);
    accCheck("R9", 64'h7FFFFFF, 1'b0);
    accCheck("R9", 64'h8000000, 1'b0);
    accCheck("R9", 64'hFFFFFFFF, 1'b1);
    sizeMirror = 1;
    cfgWrite(6'h15, 4'b1000, 32'h0100_0000);
    check("R11", lastPulse, 0, "no pulse after size write");
    readCheck("R2", 6'h15, 32'h0100_0000);
    accCheck("R9", 64'h7FFFFF, 1'b1);
    accCheck("R9", 64'h800000, 1'b0);
    sizeMirror = 255;
    cfgWrite(6'h15, 4'b1000, 32'hFF00_0000);
    accCheck("R9", 64'h7F7FFFFF, 1'b0);
    accCheck("R9", 64'h7F800000, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule